// File: doc/BRIEF.md
# Page-Granular Logical-to-Physical Address Mapper

This block translates logical page numbers into physical flash locations for a small flash array model. Each entry is a valid flag plus a block index and a page index. Data is never written in place. Every host write takes the next free page of an active block, marks the page that held the older copy as invalid, and repoints the map entry. A trim request drops the mapping and invalidates the page without using a new one. A read returns the current location, or reports a miss when the logical page is not mapped.

For a garbage collector, the block keeps a valid bit for every physical page and a count of valid pages for every block. Both can be read through a registered query port. The collector supplies fresh erased blocks through a ready/valid allocation handshake. After it has copied a page, it remaps that page through a relocation port. The relocation takes effect only if the map entry still points at the page the collector copied from. A host write that arrived during the copy therefore wins.

Top module: `l2p_mapper`

## Requirements
- R1: A host write takes a physical address made of the active block index and the active page pointer. Pages are taken in ascending order from 0 within the block. The next cycle's response has rsp_hit=1 and carries that address.
- R2: When a write or trim hits a mapped logical page, the valid bit of the old physical page is cleared and that block's count drops by one. A write or an applied relocation sets the valid bit of the new page.
- R3: A read of a mapped logical page responds one cycle later with rsp_hit=1 and the physical address from the most recent update.
- R4: A read of an unmapped or trimmed logical page responds with rsp_hit=0, and rsp_blk and rsp_page are both zero.
- R5: A trim unmaps the logical page and uses no physical page. The next write receives the page pointer that directly follows the last one used. The trim response has rsp_hit=1 only when the page was mapped.
- R6: Each block's valid count equals the number of set valid bits in that block. It is updated in the same cycle as the map update.
- R7: After the last page of the active block is used, alloc_ready is 1. While it stays 1, req_ready is 0 for a write (req_op=1), but reads (req_op=2) and trims (req_op=3) are still accepted.
- R8: An allocation handshake (alloc_valid and alloc_ready both 1) makes alloc_blk the active block with its page pointer at 0.
- R9: A relocation whose old address matches the current map entry repoints the entry to the new address. It clears the old valid bit, sets the new one, and updates both counts. The next cycle has rel_done=1 and rel_applied=1.
- R10: A relocation whose old address does not match leaves the map, the valid bits and the counts unchanged. The response is rel_done=1 and rel_applied=0.
- R11: While rel_valid is 1, req_ready is 0, so a relocation is never handled in the same cycle as a host request.
- R12: One cycle after q_blk is presented, q_count and q_bits show that block's valid count and its per-page valid bits, with bit i standing for page i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_op | input | 2 | 1 write, 2 read, 3 trim |
| req_lpn | input | 6 | Logical page number |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | Response strobe |
| rsp_op | output | 2 | Operation being answered |
| rsp_hit | output | 1 | Mapped (read/trim) or written (write) |
| rsp_blk | output | 4 | Physical block index |
| rsp_page | output | 3 | Physical page index |
| alloc_ready | output | 1 | Active block needed |
| alloc_valid | input | 1 | Allocator offers a block |
| alloc_blk | input | 4 | Offered erased block |
| rel_valid | input | 1 | Relocation request |
| rel_lpn | input | 6 | Logical page being moved |
| rel_old_blk | input | 4 | Block the copy was read from |
| rel_old_page | input | 3 | Page the copy was read from |
| rel_new_blk | input | 4 | Destination block |
| rel_new_page | input | 3 | Destination page |
| rel_done | output | 1 | Relocation handled |
| rel_applied | output | 1 | Map was updated |
| q_blk | input | 4 | Block to inspect |
| q_count | output | 4 | Valid pages in that block |
| q_bits | output | 8 | Valid bit per page |

## Verification
The assertions rely on three conditions. The allocator hands over only erased blocks, meaning every valid bit is clear and the count is zero. A relocation destination is an unused page in a block other than the active one. Requests are made only while req_ready is high. The bench keeps to these conditions: it offers each block index once, and it reserves a block for the relocation destination that the allocator never hands out. It also caps random writes by the pages still free, so allocation never runs dry. Random reads, writes and trims are checked against a reference map held in the bench. Directed cases cover block fill, trim followed by write, and matching and stale relocations.

// File: rtl/l2p_pkg.sv
package l2p_pkg;
  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_TRIM  = 2'd3
  } l2p_op_e;
endpackage

// File: rtl/l2p_map_table.sv
module l2p_map_table #(
  parameter int NUM_LPAGES = 64,
  parameter int AW         = 7,
  localparam int LW        = $clog2(NUM_LPAGES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] rd_lpn,
  output logic          rd_vld,
  output logic [AW-1:0] rd_addr,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_lpn,
  input  logic          wr_vld,
  input  logic [AW-1:0] wr_addr
);
  // address store has no reset so it can live in RAM; flags are flops
  logic [AW-1:0]         addr_mem [NUM_LPAGES];
  logic [NUM_LPAGES-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (wr_en) addr_mem[wr_lpn] <= wr_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else if (wr_en) vld_q[wr_lpn] <= wr_vld;
  end

  assign rd_vld  = vld_q[rd_lpn];
  assign rd_addr = rd_vld ? addr_mem[rd_lpn] : '0;
endmodule

// File: rtl/l2p_page_alloc.sv
module l2p_page_alloc #(
  parameter int NUM_BLOCKS      = 16,
  parameter int PAGES_PER_BLOCK = 8,
  localparam int BW = $clog2(NUM_BLOCKS),
  localparam int PW = $clog2(PAGES_PER_BLOCK)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_valid,
  input  logic [BW-1:0] alloc_blk,
  output logic          alloc_ready,
  input  logic          take,
  output logic          have_blk,
  output logic [BW-1:0] cur_blk,
  output logic [PW-1:0] cur_pg
);
  localparam logic [PW-1:0] LAST_PG = PW'(PAGES_PER_BLOCK - 1);

  assign alloc_ready = !have_blk;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_blk <= 1'b0;
      cur_blk  <= '0;
      cur_pg   <= '0;
    end else if (alloc_valid && alloc_ready) begin
      have_blk <= 1'b1;
      cur_blk  <= alloc_blk;
      cur_pg   <= '0;
    end else if (take) begin
      if (cur_pg == LAST_PG) have_blk <= 1'b0;
      else cur_pg <= cur_pg + 1'b1;
    end
  end

  AST_TAKE_NEEDS_BLOCK: assert property (@(posedge clk) disable iff (rst)
    take |-> have_blk); // R7
  AST_PAGE_ASCENDS: assert property (@(posedge clk) disable iff (rst)
    (take && cur_pg != LAST_PG) |=> (cur_pg == $past(cur_pg) + 1'b1)); // R1
  AST_ALLOC_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && alloc_ready) |=> (have_blk && cur_pg == '0)); // R8
endmodule

// File: rtl/l2p_valid_track.sv
module l2p_valid_track #(
  parameter int NUM_BLOCKS      = 16,
  parameter int PAGES_PER_BLOCK = 8,
  localparam int BW = $clog2(NUM_BLOCKS),
  localparam int PW = $clog2(PAGES_PER_BLOCK),
  localparam int AW = BW + PW,
  localparam int CW = $clog2(PAGES_PER_BLOCK + 1),
  localparam int NP = NUM_BLOCKS * PAGES_PER_BLOCK
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr_en,
  input  logic [AW-1:0]              clr_ppn,
  input  logic                       set_en,
  input  logic [AW-1:0]              set_ppn,
  input  logic [BW-1:0]              q_blk,
  output logic [CW-1:0]              q_count,
  output logic [PAGES_PER_BLOCK-1:0] q_bits
);
  logic [NP-1:0] bits_q;
  logic [CW-1:0] cnt_q [NUM_BLOCKS];

  always_ff @(posedge clk) begin
    if (rst) bits_q <= '0;
    else begin
      if (clr_en) bits_q[clr_ppn] <= 1'b0;
      if (set_en) bits_q[set_ppn] <= 1'b1;
    end
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_cnt
    logic inc, dec;
    assign inc = set_en && (set_ppn[AW-1:PW] == BW'(b));
    assign dec = clr_en && (clr_ppn[AW-1:PW] == BW'(b));
    always_ff @(posedge clk) begin
      if (rst) cnt_q[b] <= '0;
      else if (inc && !dec) cnt_q[b] <= cnt_q[b] + 1'b1;
      else if (dec && !inc) cnt_q[b] <= cnt_q[b] - 1'b1;
    end
    AST_CNT_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
      dec |-> (cnt_q[b] != '0)); // R6
    AST_CNT_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      inc |-> (cnt_q[b] != CW'(PAGES_PER_BLOCK))); // R6
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_count <= '0;
      q_bits  <= '0;
    end else begin
      q_count <= cnt_q[q_blk];
      q_bits  <= bits_q[q_blk*PAGES_PER_BLOCK +: PAGES_PER_BLOCK];
    end
  end

  AST_CLEAR_VALID_ONLY: assert property (@(posedge clk) disable iff (rst)
    clr_en |-> bits_q[clr_ppn]); // R2
  AST_SET_FREE_ONLY: assert property (@(posedge clk) disable iff (rst)
    set_en |-> !bits_q[set_ppn]); // R2
endmodule

// File: rtl/l2p_mapper.sv
module l2p_mapper #(
  parameter int NUM_BLOCKS      = 16,
  parameter int PAGES_PER_BLOCK = 8,
  parameter int NUM_LPAGES      = 64,
  localparam int BW = $clog2(NUM_BLOCKS),
  localparam int PW = $clog2(PAGES_PER_BLOCK),
  localparam int LW = $clog2(NUM_LPAGES),
  localparam int AW = BW + PW,
  localparam int CW = $clog2(PAGES_PER_BLOCK + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic [1:0]                 req_op,
  input  logic [LW-1:0]              req_lpn,
  output logic                       req_ready,
  output logic                       rsp_valid,
  output logic [1:0]                 rsp_op,
  output logic                       rsp_hit,
  output logic [BW-1:0]              rsp_blk,
  output logic [PW-1:0]              rsp_page,
  output logic                       alloc_ready,
  input  logic                       alloc_valid,
  input  logic [BW-1:0]              alloc_blk,
  input  logic                       rel_valid,
  input  logic [LW-1:0]              rel_lpn,
  input  logic [BW-1:0]              rel_old_blk,
  input  logic [PW-1:0]              rel_old_page,
  input  logic [BW-1:0]              rel_new_blk,
  input  logic [PW-1:0]              rel_new_page,
  output logic                       rel_done,
  output logic                       rel_applied,
  input  logic [BW-1:0]              q_blk,
  output logic [CW-1:0]              q_count,
  output logic [PAGES_PER_BLOCK-1:0] q_bits
);
  import l2p_pkg::*;

  logic          have_blk;
  logic [BW-1:0] cur_blk;
  logic [PW-1:0] cur_pg;
  logic [LW-1:0] look_lpn;
  logic          ent_vld;
  logic [AW-1:0] ent_addr;
  logic          acc, do_wr, do_rd, do_tr, rel_hit;
  logic          map_we, map_wvld;
  logic [AW-1:0] map_waddr, fresh_addr, rel_old, rel_new;
  logic          clr_en, set_en;
  logic [AW-1:0] set_ppn;

  // collector traffic has priority; writes also wait for an active block
  assign req_ready = !rel_valid && (have_blk || l2p_op_e'(req_op) != OP_WRITE);
  assign acc   = req_valid && req_ready;
  assign do_wr = acc && l2p_op_e'(req_op) == OP_WRITE;
  assign do_rd = acc && l2p_op_e'(req_op) == OP_READ;
  assign do_tr = acc && l2p_op_e'(req_op) == OP_TRIM;

  assign look_lpn   = rel_valid ? rel_lpn : req_lpn;
  assign fresh_addr = {cur_blk, cur_pg};
  assign rel_old    = {rel_old_blk, rel_old_page};
  assign rel_new    = {rel_new_blk, rel_new_page};
  assign rel_hit    = rel_valid && ent_vld && (ent_addr == rel_old);

  always_comb begin
    map_we    = do_wr || (do_tr && ent_vld) || rel_hit;
    map_wvld  = do_wr || rel_hit;
    map_waddr = rel_valid ? rel_new : (do_wr ? fresh_addr : '0);
    clr_en    = ((do_wr || do_tr) && ent_vld) || rel_hit;
    set_en    = do_wr || rel_hit;
    set_ppn   = rel_valid ? rel_new : fresh_addr;
  end

  l2p_map_table #(.NUM_LPAGES(NUM_LPAGES), .AW(AW)) u_map (
    .clk(clk), .rst(rst),
    .rd_lpn(look_lpn), .rd_vld(ent_vld), .rd_addr(ent_addr),
    .wr_en(map_we), .wr_lpn(look_lpn), .wr_vld(map_wvld), .wr_addr(map_waddr)
  );

  l2p_page_alloc #(.NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK)) u_alloc (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_blk(alloc_blk), .alloc_ready(alloc_ready),
    .take(do_wr), .have_blk(have_blk), .cur_blk(cur_blk), .cur_pg(cur_pg)
  );

  l2p_valid_track #(.NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK)) u_track (
    .clk(clk), .rst(rst),
    .clr_en(clr_en), .clr_ppn(ent_addr),
    .set_en(set_en), .set_ppn(set_ppn),
    .q_blk(q_blk), .q_count(q_count), .q_bits(q_bits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_op      <= 2'd0;
      rsp_hit     <= 1'b0;
      rsp_blk     <= '0;
      rsp_page    <= '0;
      rel_done    <= 1'b0;
      rel_applied <= 1'b0;
    end else begin
      rsp_valid   <= acc;
      rel_done    <= rel_valid;
      rel_applied <= rel_hit;
      if (acc) begin
        rsp_op <= req_op;
        rsp_hit <= do_wr || ent_vld;
        if (do_wr) {rsp_blk, rsp_page} <= fresh_addr;
        else if (do_rd) {rsp_blk, rsp_page} <= ent_addr;
        else {rsp_blk, rsp_page} <= '0;
      end
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    acc |=> rsp_valid); // R3
  AST_MISS_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_blk == '0 && rsp_page == '0)); // R4
  AST_REL_ACK: assert property (@(posedge clk) disable iff (rst)
    rel_valid |=> rel_done); // R9
  AST_REL_APPLIED_IMPLIES_DONE: assert property (@(posedge clk) disable iff (rst)
    rel_applied |-> rel_done); // R10
  AST_NO_HOST_DURING_REL: assert property (@(posedge clk) disable iff (rst)
    rel_valid |=> !rsp_valid); // R11
endmodule

// File: tb/l2p_mapper_test.sv
`timescale 1ns/1ps
module l2p_mapper_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic       req_valid = 0;
  logic [1:0] req_op = 0;
  logic [5:0] req_lpn = 0;
  logic       req_ready, rsp_valid, rsp_hit, alloc_ready;
  logic [1:0] rsp_op;
  logic [3:0] rsp_blk;
  logic [2:0] rsp_page;
  logic       alloc_valid = 0;
  logic [3:0] alloc_blk = 0;
  logic       rel_valid = 0;
  logic [5:0] rel_lpn = 0;
  logic [3:0] rel_old_blk = 0, rel_new_blk = 0;
  logic [2:0] rel_old_page = 0, rel_new_page = 0;
  logic       rel_done, rel_applied;
  logic [3:0] q_blk = 0;
  logic [3:0] q_count;
  logic [7:0] q_bits;

  l2p_mapper uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_op(req_op), .req_lpn(req_lpn), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_op(rsp_op), .rsp_hit(rsp_hit),
    .rsp_blk(rsp_blk), .rsp_page(rsp_page),
    .alloc_ready(alloc_ready), .alloc_valid(alloc_valid), .alloc_blk(alloc_blk),
    .rel_valid(rel_valid), .rel_lpn(rel_lpn),
    .rel_old_blk(rel_old_blk), .rel_old_page(rel_old_page),
    .rel_new_blk(rel_new_blk), .rel_new_page(rel_new_page),
    .rel_done(rel_done), .rel_applied(rel_applied),
    .q_blk(q_blk), .q_count(q_count), .q_bits(q_bits)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference state
  bit         m_vld [64];
  int         m_blk [64], m_pg [64];
  bit [127:0] m_bm;
  int         m_cnt [16];
  bit         used [16];
  bit         m_act;
  int         m_ablk, m_ptr;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int pages_left();
    int n = m_act ? (8 - m_ptr) : 0;
    for (int b = 0; b < 16; b++) if (!used[b]) n += 8;
    return n;
  endfunction

  function automatic void m_invalidate(int l);
    if (m_vld[l]) begin
      m_bm[m_blk[l]*8 + m_pg[l]] = 0;
      m_cnt[m_blk[l]]--;
      m_vld[l] = 0;
    end
  endfunction

  function automatic void m_place(int l, int b, int p);
    m_vld[l] = 1; m_blk[l] = b; m_pg[l] = p;
    m_bm[b*8 + p] = 1;
    m_cnt[b]++;
  endfunction

  function automatic int next_free_blk();
    for (int b = 0; b < 16; b++) if (!used[b]) return b;
    return -1;
  endfunction

  task automatic give_block(int b);
    chk("R7 alloc_ready when no block", alloc_ready, 1);
    alloc_valid = 1; alloc_blk = 4'(b);
    @(negedge clk);
    alloc_valid = 0;
    used[b] = 1; m_act = 1; m_ablk = b; m_ptr = 0;
  endtask

  task automatic do_write(int l, string tag);
    if (!m_act) begin
      req_op = 2'd1;
      #1;
      chk("R7 write stalled without block", req_ready, 0);
      give_block(next_free_blk());
    end
    req_valid = 1; req_op = 2'd1; req_lpn = 6'(l);
    #1;
    chk({tag, " ready"}, req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    chk({tag, " write hit"}, rsp_hit, 1);
    chk({tag, " write blk"}, rsp_blk, m_ablk);
    chk({tag, " write page"}, rsp_page, m_ptr);
    m_invalidate(l);
    m_place(l, m_ablk, m_ptr);
    if (m_ptr == 7) m_act = 0; else m_ptr++;
  endtask

  task automatic do_read(int l, string tag);
    req_valid = 1; req_op = 2'd2; req_lpn = 6'(l);
    @(negedge clk);
    req_valid = 0;
    chk({tag, " rsp_valid"}, rsp_valid, 1);
    chk({tag, " hit"}, rsp_hit, m_vld[l]);
    chk({tag, " blk"}, rsp_blk, m_vld[l] ? m_blk[l] : 0);
    chk({tag, " page"}, rsp_page, m_vld[l] ? m_pg[l] : 0);
  endtask

  task automatic do_trim(int l, string tag);
    req_valid = 1; req_op = 2'd3; req_lpn = 6'(l);
    @(negedge clk);
    req_valid = 0;
    chk({tag, " trim hit"}, rsp_hit, m_vld[l]);
    m_invalidate(l);
  endtask

  task automatic qcheck(int b, string tag);
    q_blk = 4'(b);
    @(negedge clk);
    chk({tag, " count"}, q_count, m_cnt[b]);
    chk({tag, " bits"}, q_bits, m_bm[b*8 +: 8]);
  endtask

  task automatic do_rel(int l, int ob, int op, int nb, int np, int exp_app, string tag);
    rel_valid = 1; rel_lpn = 6'(l);
    rel_old_blk = 4'(ob); rel_old_page = 3'(op);
    rel_new_blk = 4'(nb); rel_new_page = 3'(np);
    req_op = 2'd2;
    #1;
    chk("R11 host blocked during relocate", req_ready, 0);
    @(negedge clk);
    rel_valid = 0;
    chk({tag, " done"}, rel_done, 1);
    chk({tag, " applied"}, rel_applied, exp_app);
    if (exp_app != 0) begin
      m_invalidate(l);
      m_place(l, nb, np);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    m_bm = '0; m_act = 0; m_ablk = 0; m_ptr = 0;
    for (int i = 0; i < 64; i++) begin m_vld[i] = 0; m_blk[i] = 0; m_pg[i] = 0; end
    for (int b = 0; b < 16; b++) begin m_cnt[b] = 0; used[b] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // reset state
    chk("R7 reset alloc_ready", alloc_ready, 1);
    chk("R3 reset rsp_valid", rsp_valid, 0);
    chk("R9 reset rel_done", rel_done, 0);
    qcheck(0, "R12 reset blk0");

    do_read(5, "R4 read unmapped");
    used[0] = 1; // keep block 0 out of circulation so block 3 can go first
    give_block(3);
    used[0] = 0;
    do_write(5, "R1 first write");
    do_write(6, "R1 second write");
    do_write(5, "R2 rewrite");
    qcheck(3, "R6 R2 blk3 after rewrite");
    do_read(5, "R3 read rewritten");
    do_trim(6, "R5 trim mapped");
    do_read(6, "R4 read trimmed");
    do_trim(6, "R5 trim unmapped");
    do_write(7, "R5 write after trim");
    for (int l = 8; l < 12; l++) do_write(l, "R1 fill block");
    chk("R7 alloc_ready after fill", alloc_ready, 1);
    req_op = 2'd1;
    #1;
    chk("R7 write not ready", req_ready, 0);
    do_read(8, "R7 read with no block");
    do_trim(9, "R7 trim with no block");
    qcheck(3, "R12 blk3 after fill");
    used[10] = 1; // collector destination, never given to the host path
    do_write(12, "R8 write in new block");
    do_rel(5, 3, 2, 10, 0, 1, "R9 relocate match");
    do_read(5, "R9 read relocated");
    qcheck(3, "R9 blk3 count");
    qcheck(10, "R9 blk10 count");
    do_rel(5, 3, 2, 10, 1, 0, "R10 stale relocate");
    do_read(5, "R10 map unchanged");
    qcheck(10, "R10 blk10 unchanged");

    // constrained random mix
    for (int it = 0; it < 600; it++) begin
      int r = int'($urandom % 4);
      int l = int'($urandom % 64);
      if (r == 0 && pages_left() > 0) do_write(l, "R2 random write");
      else if (r == 1) do_trim(l, "R5 random trim");
      else do_read(l, "R3 random read");
      if (it % 16 == 0) qcheck(int'($urandom % 16), "R6 random query");
    end
    for (int b = 0; b < 16; b++) qcheck(b, "R6 final sweep");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule